// File: doc/BRIEF.md
# Four-Lane Alignment Deskew Unit

This block sits behind four byte lanes that have each been synchronized and decoded on their own. Every lane carries a data byte, a control flag and a sync status. Because each lane recovers its own timing, the same transmitted row of four bytes can reach the block spread over several clock cycles. The transmitter sends an alignment marker on all four lanes in the same row at fixed points of the inter-packet gap. The block finds that marker on every lane and holds back the earlier lanes until the markers meet. It then puts out one 32-bit word with four control bits per cycle.

Each lane passes through a short tapped delay line. A marker window logs, relative to the first marker of a row, the cycle in which each lane saw its marker. This gives a delay per lane. A lock machine accepts those delays once four full marker rows in a row have produced the same set. Until then, and whenever alignment is lost, the output carries an idle pattern and the valid flag stays low.

Top module: `quad_lane_deskew`

## Requirements
- R1: While reset is held, `out_valid` is 0, every `out_ctrl` bit is 1 and every output byte is 8'h07 (the idle character).
- R2: A lane carries the alignment marker in a cycle when its control flag is 1 and its byte is 8'h7C. A byte of 8'h7C with the control flag at 0 is data and is never taken as a marker.
- R3: `out_valid` rises only after four consecutive complete marker rows have given the same set of relative lane offsets. It rises in the same cycle that the fourth marker row appears on the output, and not earlier.
- R4: While `out_valid` is 1, output lane i (bits 8i+7..8i and `out_ctrl[i]`) carries input lane i's symbol, realigned. The word shown after a clock edge is the transmitted row whose last-arriving lane was captured on that edge.
- R5: Any combination of lane skews in which the latest lane trails the earliest by at most MAX_SKEW = 4 cycles is absorbed.
- R6: If one lane trails the earliest lane by 5 or more cycles, the block never sets `out_valid`.
- R7: If a marker appears on some lanes but not on all of them within 4 cycles of the first, the row counts as failed. Alignment is dropped on the next edge and the count of good rows restarts from zero.
- R8: If any `rx_sync` bit is 0 on a clock edge, `out_valid` is 0 after that edge and the good-row count restarts.
- R9: While aligned, a complete marker row whose lane offsets differ from the locked ones drops `out_valid` on the next edge. That row counts as the first row of the new hunt.
- R10: Whenever `out_valid` is 0, the output shows the idle pattern of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes after their own recovery |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_data | input | 32 | Decoded bytes, lane i at bits 8i+7..8i |
| rx_ctrl | input | 4 | Control flag per lane |
| rx_sync | input | 4 | Per-lane synchronization status, 1 = in sync |
| out_data | output | 32 | Realigned word, lane i at bits 8i+7..8i |
| out_ctrl | output | 4 | Realigned control flags |
| out_valid | output | 1 | High while the lanes are aligned |

## Verification
The bench works the skew window at both ends. A spread of exactly four cycles must lock; a design with an off-by-one window bound would reject it. A spread of five must never lock; a design that let the window run one cycle long would accept it. The lock instant is checked against the fourth marker row exactly, which catches a counter that locks on the third or the fifth row. A design that kept stale delays after the skew pattern changes, or that ignored a lone missing marker, would keep `out_valid` high over garbage, and the bench drops a marker and changes the skew while locked to expose both. A single lane losing sync must drop valid on the next edge.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  // lane symbol values the block recognises or produces
  localparam logic [7:0] MARK_CHAR = 8'h7C;
  localparam logic [7:0] IDLE_CHAR = 8'h07;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/lane_delay.sv
module lane_delay #(
  parameter int          SYM_W    = 9,
  parameter int          MAX_SKEW = 4,
  parameter int          SEL_W    = 3,
  parameter logic [SYM_W-1:0] RST_SYM = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] din,
  input  logic [SEL_W-1:0] sel,
  output logic [SYM_W-1:0] dout
);
  logic [SYM_W-1:0] line_q [MAX_SKEW];
  logic [SYM_W-1:0] tap;

  // delay line: stage k holds the symbol from k+1 cycles ago
  generate
    for (genvar k = 0; k < MAX_SKEW; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) line_q[k] <= RST_SYM;
          else        line_q[k] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) line_q[k] <= RST_SYM;
          else        line_q[k] <= line_q[k-1];
        end
      end
    end
  endgenerate

  always_comb begin
    tap = din;
    for (int k = 0; k < MAX_SKEW; k++) begin
      if (sel == SEL_W'(k + 1)) tap = line_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= RST_SYM;
    else        dout <= tap;
  end

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel <= SEL_W'(MAX_SKEW)); // R5
endmodule

// File: rtl/marker_window.sv
module marker_window #(
  parameter int LANES    = 4,
  parameter int MAX_SKEW = 4,
  parameter int SEL_W    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       hit,
  input  logic                   sync_all,
  output logic                   event_ok,
  output logic                   event_bad,
  output logic [LANES*SEL_W-1:0] delay_flat
);
  logic                 win_q, win_d;
  logic [SEL_W-1:0]     wcnt_q, wcnt_d;
  logic [LANES-1:0]     seen_q, seen_d, seen_n;
  logic [SEL_W-1:0]     off_q [LANES];
  logic [SEL_W-1:0]     off_d [LANES];
  logic [SEL_W-1:0]     cur;
  logic                 complete, expire;

  // offset of the current cycle from the first marker of the row
  always_comb begin
    cur      = win_q ? (wcnt_q + SEL_W'(1)) : '0;
    seen_n   = (win_q ? seen_q : '0) | hit;
    complete = sync_all && (win_q || (|hit)) && (&seen_n);
    expire   = sync_all && win_q && !complete && (cur == SEL_W'(MAX_SKEW));
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_dly
      logic [SEL_W-1:0] off_eff;
      always_comb begin
        off_eff = (win_q && seen_q[i]) ? off_q[i] : cur;
        delay_flat[i*SEL_W +: SEL_W] = cur - off_eff;
      end
    end
  endgenerate

  assign event_ok  = complete;
  assign event_bad = expire;

  // next state
  always_comb begin
    win_d  = win_q;
    wcnt_d = wcnt_q;
    seen_d = seen_q;
    for (int i = 0; i < LANES; i++) off_d[i] = off_q[i];
    if (!sync_all || complete || expire) begin
      win_d  = 1'b0;
      seen_d = '0;
    end else if (!win_q && (|hit)) begin
      win_d  = 1'b1;
      wcnt_d = '0;
      seen_d = hit;
      for (int i = 0; i < LANES; i++) if (hit[i]) off_d[i] = '0;
    end else if (win_q) begin
      wcnt_d = cur;
      seen_d = seen_n;
      for (int i = 0; i < LANES; i++) if (hit[i] && !seen_q[i]) off_d[i] = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      wcnt_q <= '0;
      seen_q <= '0;
      for (int i = 0; i < LANES; i++) off_q[i] <= '0;
    end else begin
      win_q  <= win_d;
      wcnt_q <= wcnt_d;
      seen_q <= seen_d;
      for (int i = 0; i < LANES; i++) off_q[i] <= off_d[i];
    end
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |-> (wcnt_q < SEL_W'(MAX_SKEW))); // R7
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import deskew_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SEL_W       = 3,
  parameter int LOCK_EVENTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_all,
  input  logic                   event_ok,
  input  logic                   event_bad,
  input  logic [LANES*SEL_W-1:0] delay_in,
  output logic [LANES*SEL_W-1:0] delay_q,
  output logic                   locked
);
  localparam int CW = $clog2(LOCK_EVENTS + 1);

  lock_state_e            state_q, state_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic [LANES*SEL_W-1:0] delay_d;
  logic                   same;
  logic [CW-1:0]          cnt_inc;

  always_comb begin
    same    = (delay_in == delay_q);
    cnt_inc = (same && cnt_q != '0) ? (cnt_q + CW'(1)) : CW'(1);
    state_d = state_q;
    cnt_d   = cnt_q;
    delay_d = delay_q;
    if (!sync_all || event_bad) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end else if (event_ok) begin
      delay_d = delay_in;
      if (state_q == ST_LOCKED) begin
        if (!same) begin
          state_d = ST_HUNT;
          cnt_d   = CW'(1);
        end
      end else begin
        cnt_d = cnt_inc;
        if (cnt_inc == CW'(LOCK_EVENTS)) state_d = ST_LOCKED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      delay_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      delay_q <= delay_d;
    end
  end

  assign locked = (state_q == ST_LOCKED);

  AST_LOCK_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(event_ok)); // R3
  AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && event_bad) |=> !locked); // R7
  AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_all |=> !locked); // R8
  AST_SHIFT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && event_ok && (delay_in != delay_q)) |=> !locked); // R9
endmodule

// File: rtl/quad_lane_deskew.sv
module quad_lane_deskew
  import deskew_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int BYTE_W      = 8,
  parameter int MAX_SKEW    = 4,
  parameter int LOCK_EVENTS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES*BYTE_W-1:0]   rx_data,
  input  logic [LANES-1:0]          rx_ctrl,
  input  logic [LANES-1:0]          rx_sync,
  output logic [LANES*BYTE_W-1:0]   out_data,
  output logic [LANES-1:0]          out_ctrl,
  output logic                      out_valid
);
  localparam int SEL_W = $clog2(MAX_SKEW + 1);
  localparam int SYM_W = BYTE_W + 1;
  localparam logic [SYM_W-1:0] IDLE_SYM = {1'b1, BYTE_W'(IDLE_CHAR)};

  logic                   sync_all;
  logic [LANES-1:0]       hit;
  logic                   event_ok, event_bad, locked;
  logic [LANES*SEL_W-1:0] delay_new, delay_use;
  logic [SYM_W-1:0]       staged [LANES];

  assign sync_all = &rx_sync;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign hit[i] = rx_ctrl[i] && (rx_data[i*BYTE_W +: BYTE_W] == BYTE_W'(MARK_CHAR));

      lane_delay #(
        .SYM_W   (SYM_W),
        .MAX_SKEW(MAX_SKEW),
        .SEL_W   (SEL_W),
        .RST_SYM (IDLE_SYM)
      ) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({rx_ctrl[i], rx_data[i*BYTE_W +: BYTE_W]}),
        .sel  (delay_use[i*SEL_W +: SEL_W]),
        .dout (staged[i])
      );

      always_comb begin
        if (locked) begin
          out_ctrl[i]                  = staged[i][SYM_W-1];
          out_data[i*BYTE_W +: BYTE_W] = staged[i][BYTE_W-1:0];
        end else begin
          out_ctrl[i]                  = 1'b1;
          out_data[i*BYTE_W +: BYTE_W] = BYTE_W'(IDLE_CHAR);
        end
      end
    end
  endgenerate

  marker_window #(
    .LANES   (LANES),
    .MAX_SKEW(MAX_SKEW),
    .SEL_W   (SEL_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .sync_all  (sync_all),
    .event_ok  (event_ok),
    .event_bad (event_bad),
    .delay_flat(delay_new)
  );

  lock_fsm #(
    .LANES      (LANES),
    .SEL_W      (SEL_W),
    .LOCK_EVENTS(LOCK_EVENTS)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_all (sync_all),
    .event_ok (event_ok),
    .event_bad(event_bad),
    .delay_in (delay_new),
    .delay_q  (delay_use),
    .locked   (locked)
  );

  assign out_valid = locked;

  AST_VALID_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sync != {LANES{1'b1}}) |=> !out_valid); // R8
endmodule

// File: tb/quad_lane_deskew_tb.sv
module quad_lane_deskew_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] rx_data;
  logic [3:0]  rx_ctrl;
  logic [3:0]  rx_sync;
  logic [31:0] out_data;
  logic [3:0]  out_ctrl;
  logic        out_valid;

  quad_lane_deskew u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .rx_sync(rx_sync), .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int          due;
    logic [31:0] d;
    logic [3:0]  k;
    int          aidx;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   tests = 0;
  int   fails = 0;
  int   skew[4];
  int   smax = 0;
  int   gen_start = 1000000;
  int   corrupt_t = -1;
  int   corrupt_lane = 0;
  int   a_idx = 0;
  bit   cmp_en = 1'b1;
  bit   expect_lock = 1'b1;
  bit   saw_valid = 1'b0;
  bit   prev_valid = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // symbol of transmitted row t on lane ln: {ctrl, byte}
  function automatic logic [8:0] lane_sym(int t, int ln);
    if (t < gen_start)                       return {1'b1, 8'h07};
    if ((t % 16) == 0) begin
      if (t == corrupt_t && ln == corrupt_lane) return {1'b1, 8'h07};
      return {1'b1, 8'h7C};
    end
    if ((t % 16) <= 3)                       return {1'b1, 8'h07};
    return {1'b0, 8'(t * 4 + ln)};
  endfunction

  task automatic set_skew(input int s0, input int s1, input int s2, input int s3);
    skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    smax = 0;
    for (int i = 0; i < 4; i++) if (skew[i] > smax) smax = skew[i];
  endtask

  task automatic drive();
    int   t;
    exp_t it;
    logic [8:0] s;
    t = cyc + 1;
    for (int i = 0; i < 4; i++) begin
      s = lane_sym(t - skew[i], i);
      rx_ctrl[i]        = s[8];
      rx_data[i*8 +: 8] = s[7:0];
    end
    if (rst_n && t >= gen_start) begin
      it.due = t + smax;
      it.aidx = 0;
      for (int i = 0; i < 4; i++) begin
        s = lane_sym(t, i);
        it.k[i]        = s[8];
        it.d[i*8 +: 8] = s[7:0];
      end
      if ((t % 16) == 0) begin
        if (t == corrupt_t) a_idx = 0;
        else begin
          a_idx++;
          it.aidx = a_idx;
        end
      end
      q.push_back(it);
    end
  endtask

  task automatic step();
    @(negedge clk);
    drive();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_pos(input int p);
    step();
    while (((cyc + 1) % 16) != p) step();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t it;
      while (q.size() > 0 && q[0].due < cyc) void'(q.pop_front());
      if (q.size() > 0 && q[0].due == cyc) begin
        it = q.pop_front();
        if (out_valid && cmp_en)
          chk({out_ctrl, out_data} == {it.k, it.d}, "R4 realigned word",
              {28'd0, out_ctrl, out_data}, {28'd0, it.k, it.d});
        if (expect_lock && it.aidx == 3)
          chk(!out_valid, "R3 no lock at third row", out_valid, 0);
        if (expect_lock && it.aidx == 4)
          chk(out_valid && !prev_valid, "R3 lock at fourth row",
              {prev_valid, out_valid}, 2'b01);
      end
      if (!out_valid) begin
        cmp_en = 1'b1;
        chk({out_ctrl, out_data} == {4'hF, 32'h07070707}, "R10 idle while hunting",
            {out_ctrl, out_data}, {4'hF, 32'h07070707});
      end else begin
        saw_valid = 1'b1;
      end
      prev_valid = out_valid;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    rx_sync = 4'hF;
    rx_data = '0;
    rx_ctrl = '0;
    set_skew(0, 2, 1, 3);
    run(4);
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk(out_ctrl == 4'hF, "R1 reset ctrl", out_ctrl, 4'hF);
    chk(out_data == 32'h07070707, "R1 reset data", out_data, 32'h07070707);

    // R2: 7C bytes sent as data must not be taken as markers
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rx_data = 32'h7C7C7C7C;
      rx_ctrl = 4'h0;
    end
    chk(!saw_valid, "R2 data 7C not a marker", saw_valid, 0);

    // R3/R4/R5: lock with a skew spread of 3
    @(negedge clk);
    gen_start = cyc + 2;
    a_idx = 0;
    drive();
    run(110);
    chk(out_valid, "R5 locked with skew 0,2,1,3", out_valid, 1);

    // R8: one lane loses sync
    wait_pos(8);
    rx_sync = 4'b1011;
    step();
    chk(!out_valid, "R8 sync loss drops valid", out_valid, 0);
    rx_sync = 4'hF;
    a_idx = 0;
    run(90);
    chk(out_valid, "R8 relock after sync loss", out_valid, 1);

    // R7: marker missing on one lane
    wait_pos(8);
    corrupt_t = ((cyc + 1) / 16 + 1) * 16;
    corrupt_lane = 1;
    run(24);
    chk(!out_valid, "R7 partial marker drops valid", out_valid, 0);
    run(80);
    chk(out_valid, "R7 relock after partial marker", out_valid, 1);

    // R9 + R5: skew pattern changes while locked, spread of 4
    wait_pos(8);
    set_skew(4, 0, 3, 1);
    q.delete();
    cmp_en = 1'b0;
    a_idx = 0;
    run(24);
    chk(!out_valid, "R9 offset change drops valid", out_valid, 0);
    run(90);
    chk(out_valid, "R5 locked with spread of 4", out_valid, 1);

    // R6: spread of 5 never locks
    wait_pos(8);
    set_skew(0, 5, 0, 0);
    q.delete();
    cmp_en = 1'b0;
    expect_lock = 1'b0;
    run(24);
    chk(!out_valid, "R6 lost lock on spread of 5", out_valid, 0);
    saw_valid = 1'b0;
    run(120);
    chk(!saw_valid, "R6 no lock with spread of 5", saw_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule